// File: doc/BRIEF.md
# Interlaced SD Video Master Sync Generator

This block produces the horizontal sync, vertical sync and blanking strobes for an interlaced standard-definition raster. It needs no timing reference from outside. The core clock runs at twice the sample rate, and an internal divider gives one sample tick every second clock. A sample counter and a line counter then step through the raster. A single select input picks the 525-line or the 625-line timing set. Each field start is signalled by the timing of the vertical sync falling edge relative to the horizontal sync falling edge. The odd field starts when both edges fall together at the start of a line. The even field starts when the vertical edge falls on its own at mid-line.

The generator runs only when the low three bits of an 8-bit mode byte hold the master code. With any other code, all strobes stay inactive and the raster is held at its start position. If external blanking is not enabled, the block also blanks the vertical-interval lines of both fields on top of the per-line horizontal blanking. All line and sample counts are parameters, so the same block can run a scaled-down raster.

Top module: `sdtv_sync_master`

## Requirements
- R1: The generator runs only while mode_byte[2:0] equals 3'b101, whatever mode_byte[7:3] holds. With any other code, hsync_n, vsync_n and blank_n are 1, field_odd is 1, and the raster is held at line 1, sample 0. The next enable then starts as if from reset.
- R2: The raster advances by one sample every two clocks. A line lasts 858 samples when std_625=0 and 864 samples when std_625=1, so hsync_n falls every 1716 or 1728 clocks.
- R3: hsync_n is 0 for samples 0 to 15 of every line with std_625=0, and for samples 0 to 11 with std_625=1. It is 1 for the rest of the line.
- R4: blank_n is 0 for samples 0 to 121 (std_625=0) or 0 to 131 (std_625=1) of every line, and active video starts on the sample after that.
- R5: At line 1, sample 0, vsync_n and hsync_n fall on the same clock, which starts the odd field. vsync_n stays 0 for three whole lines.
- R6: vsync_n falls at the mid-line sample of line 263 (sample 429, std_625=0) or of line 313 (sample 432, std_625=1) while hsync_n is 1, which starts the even field. It stays 0 until the same sample three lines later.
- R7: field_odd is 1 from the odd-field vsync edge and 0 from the even-field vsync edge, so it changes on every vsync_n falling edge.
- R8: With ext_blank_en=0, blank_n is 0 for the whole of every vertical-interval line. These are lines 1–21 and 263–284 with std_625=0, and lines 623–625, 1–22 and 311–335 with std_625=1. With ext_blank_en=1, only the horizontal blanking of R4 appears.
- R9: A frame has 525 or 625 lines. A change of std_625 takes effect only when the raster wraps from its last line to line 1. While rst is 1, all outputs are inactive (1), and the raster restarts at line 1, sample 0 in the odd field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| mode_byte | input | 8 | Timing control byte; low three bits 3'b101 enable master generation |
| std_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| ext_blank_en | input | 1 | 1 leaves vertical blanking to an external source |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Blanking strobe, active low |
| field_odd | output | 1 | 1 in the odd field, 0 in the even field |

## Verification
The bench runs the block with a scaled-down raster, so that many whole frames of both standards fit in one run. It changes std_625 in the middle of a frame. A design that switched at once would put hsync_n at the wrong spacing and vsync_n on the wrong line. The bench also looks at the mid-line edge of the even field: a design with an off-by-one half-line position, or with vsync_n tied to the hsync edge, would lose the field identity and flip field_odd on the wrong clock. It toggles external blanking and drops the mode code with random upper bits set, which would expose vertical blanking that leaks through or a raster that does not restart from line 1 on re-enable.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

   // Timing conditions decoded for one standard at the current raster position
   typedef struct packed {
      logic hs;      // horizontal sync interval
      logic vs;      // vertical sync interval
      logic hblank;  // horizontal blanking interval
      logic vblank;  // vertical-interval line
      logic odd;     // position lies in the odd field
   } sync_cond_t;

   localparam logic [2:0] MASTER_CODE = 3'b101;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sync_tick_gen.sv
module sync_tick_gen (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   logic phase_q;

   always_ff @(posedge clk) begin
      if (rst || !run) phase_q <= 1'b0;
      else             phase_q <= ~phase_q;
   end

   // the raster advances on the second clock of each pair
   assign tick = phase_q;
endmodule

// File: rtl/sync_raster.sv
module sync_raster #(
   parameter int unsigned SW     = 10,
   parameter int unsigned LW     = 10,
   parameter int unsigned SAMP_A = 858,
   parameter int unsigned SAMP_B = 864,
   parameter int unsigned LINE_A = 525,
   parameter int unsigned LINE_B = 625
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          run,
   input  logic          tick,
   input  logic          std_in,
   output logic [SW-1:0] samp,
   output logic [LW-1:0] line,
   output logic          std_q
);
   localparam logic [SW-1:0] LAST_SAMP_A = SW'(SAMP_A - 1);
   localparam logic [SW-1:0] LAST_SAMP_B = SW'(SAMP_B - 1);
   localparam logic [LW-1:0] LAST_LINE_A = LW'(LINE_A);
   localparam logic [LW-1:0] LAST_LINE_B = LW'(LINE_B);
   localparam logic [LW-1:0] FIRST_LINE  = LW'(1);

   logic [SW-1:0] samp_last;
   logic [LW-1:0] line_last;

   assign samp_last = std_q ? LAST_SAMP_B : LAST_SAMP_A;
   assign line_last = std_q ? LAST_LINE_B : LAST_LINE_A;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         samp  <= '0;
         line  <= FIRST_LINE;
         std_q <= std_in;
      end else if (tick) begin
         if (samp == samp_last) begin
            samp <= '0;
            if (line == line_last) begin
               line  <= FIRST_LINE;
               std_q <= std_in;          // standard switches only at frame wrap
            end else begin
               line <= line + LW'(1);
            end
         end else begin
            samp <= samp + SW'(1);
         end
      end
   end
endmodule

// File: rtl/sync_std_decode.sv
module sync_std_decode
   import sync_gen_pkg::*;
#(
   parameter int unsigned SW       = 10,
   parameter int unsigned LW       = 10,
   parameter int unsigned SAMPS    = 858,
   parameter int unsigned HS_LEN   = 16,
   parameter int unsigned BLK_END  = 122,
   parameter int unsigned EVEN_LN  = 263,
   parameter int unsigned VS_LINES = 3,
   parameter int unsigned VB_WRAP  = 526,
   parameter int unsigned VB_HEAD  = 21,
   parameter int unsigned VB_MID_LO = 263,
   parameter int unsigned VB_MID_HI = 284
) (
   input  logic [SW-1:0] samp,
   input  logic [LW-1:0] line,
   output sync_cond_t    cond
);
   localparam logic [SW-1:0] HALF_S  = SW'(SAMPS / 2);
   localparam logic [SW-1:0] HS_S    = SW'(HS_LEN);
   localparam logic [SW-1:0] BLK_S   = SW'(BLK_END);
   localparam logic [LW-1:0] EVEN_L  = LW'(EVEN_LN);
   localparam logic [LW-1:0] EVEN_EL = LW'(EVEN_LN + VS_LINES);
   localparam logic [LW-1:0] ODD_EL  = LW'(VS_LINES);
   localparam logic [LW-1:0] WRAP_L  = LW'(VB_WRAP);
   localparam logic [LW-1:0] HEAD_L  = LW'(VB_HEAD);
   localparam logic [LW-1:0] MLO_L   = LW'(VB_MID_LO);
   localparam logic [LW-1:0] MHI_L   = LW'(VB_MID_HI);

   logic first_half;
   logic vs_odd, vs_even;

   assign first_half = (samp < HALF_S);

   // odd-field sync spans whole lines 1 .. VS_LINES
   assign vs_odd  = (line <= ODD_EL);
   // even-field sync runs from mid-line to mid-line
   assign vs_even = ((line == EVEN_L) && !first_half) ||
                    ((line > EVEN_L) && (line < EVEN_EL)) ||
                    ((line == EVEN_EL) && first_half);

   always_comb begin
      cond.hs     = (samp < HS_S);
      cond.hblank = (samp < BLK_S);
      cond.vs     = vs_odd || vs_even;
      cond.vblank = (line >= WRAP_L) || (line <= HEAD_L) ||
                    ((line >= MLO_L) && (line <= MHI_L));
      cond.odd    = (line < EVEN_L) || ((line == EVEN_L) && first_half);
   end
endmodule

// File: rtl/sdtv_sync_master.sv
module sdtv_sync_master
   import sync_gen_pkg::*;
#(
   parameter int unsigned SAMP_525   = 858,
   parameter int unsigned SAMP_625   = 864,
   parameter int unsigned HS_525     = 16,
   parameter int unsigned HS_625     = 12,
   parameter int unsigned BLK_525    = 122,
   parameter int unsigned BLK_625    = 132,
   parameter int unsigned LINES_525  = 525,
   parameter int unsigned LINES_625  = 625,
   parameter int unsigned EVEN_525   = 263,
   parameter int unsigned EVEN_625   = 313,
   parameter int unsigned VS_LINES   = 3,
   parameter int unsigned VBW_525    = 526,
   parameter int unsigned VBW_625    = 623,
   parameter int unsigned VBH_525    = 21,
   parameter int unsigned VBH_625    = 22,
   parameter int unsigned VBML_525   = 263,
   parameter int unsigned VBML_625   = 311,
   parameter int unsigned VBMH_525   = 284,
   parameter int unsigned VBMH_625   = 335
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] mode_byte,
   input  logic       std_625,
   input  logic       ext_blank_en,
   output logic       hsync_n,
   output logic       vsync_n,
   output logic       blank_n,
   output logic       field_odd
);
   localparam int unsigned SW = $clog2(max2(SAMP_525, SAMP_625));
   localparam int unsigned LW = $clog2(max2(LINES_525, LINES_625) + 2);

   // elaboration-time parameter checks
   if (!(HS_525 >= 2 && HS_525 < BLK_525 && BLK_525 < SAMP_525 / 2))
      begin : g_bad_h525 $error("525 horizontal timing out of order"); end
   if (!(HS_625 >= 2 && HS_625 < BLK_625 && BLK_625 < SAMP_625 / 2))
      begin : g_bad_h625 $error("625 horizontal timing out of order"); end
   if (!(EVEN_525 + VS_LINES <= LINES_525 && VBW_525 <= LINES_525 + 1))
      begin : g_bad_v525 $error("525 vertical timing out of range"); end
   if (!(EVEN_625 + VS_LINES <= LINES_625 && VBW_625 <= LINES_625 + 1))
      begin : g_bad_v625 $error("625 vertical timing out of range"); end
   if (!(VS_LINES >= 1 && VS_LINES < EVEN_525 && VS_LINES < EVEN_625))
      begin : g_bad_vs $error("vertical sync length out of range"); end

   logic          run, tick, std_q, active;
   logic [SW-1:0] samp;
   logic [LW-1:0] line;
   sync_cond_t    cond [2];
   sync_cond_t    sel;

   assign run = (mode_byte[2:0] == MASTER_CODE);

   sync_tick_gen u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .tick (tick)
   );

   sync_raster #(
      .SW(SW), .LW(LW),
      .SAMP_A(SAMP_525), .SAMP_B(SAMP_625),
      .LINE_A(LINES_525), .LINE_B(LINES_625)
   ) u_raster (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .tick   (tick),
      .std_in (std_625),
      .samp   (samp),
      .line   (line),
      .std_q  (std_q)
   );

   // one decoder per standard; index 0 = 525-line, 1 = 625-line
   for (genvar g = 0; g < 2; g++) begin : g_std
      sync_std_decode #(
         .SW(SW), .LW(LW),
         .SAMPS    (g == 0 ? SAMP_525  : SAMP_625),
         .HS_LEN   (g == 0 ? HS_525    : HS_625),
         .BLK_END  (g == 0 ? BLK_525   : BLK_625),
         .EVEN_LN  (g == 0 ? EVEN_525  : EVEN_625),
         .VS_LINES (VS_LINES),
         .VB_WRAP  (g == 0 ? VBW_525   : VBW_625),
         .VB_HEAD  (g == 0 ? VBH_525   : VBH_625),
         .VB_MID_LO(g == 0 ? VBML_525  : VBML_625),
         .VB_MID_HI(g == 0 ? VBMH_525  : VBMH_625)
      ) u_dec (
         .samp (samp),
         .line (line),
         .cond (cond[g])
      );
   end

   assign sel    = std_q ? cond[1] : cond[0];
   assign active = run && !rst;

   assign hsync_n   = !(active && sel.hs);
   assign vsync_n   = !(active && sel.vs);
   assign blank_n   = !(active && (sel.hblank || (!ext_blank_en && sel.vblank)));
   assign field_odd = !active || sel.odd;
endmodule

// File: rtl/sdtv_sync_master_chk.sv
module sdtv_sync_master_chk (
   input logic       clk,
   input logic       rst,
   input logic [7:0] mode_byte,
   input logic       std_625,
   input logic       ext_blank_en,
   input logic       hsync_n,
   input logic       vsync_n,
   input logic       blank_n,
   input logic       field_odd
);
   logic run_w;
   assign run_w = (mode_byte[2:0] == 3'b101);

   // R1: outside the master code every strobe is idle
   a_r1_idle_outputs: assert property (@(posedge clk) disable iff (rst)
      !run_w |-> (hsync_n && vsync_n && blank_n && field_odd));

   // R4: the sync pulse always sits inside horizontal blanking
   a_r4_sync_inside_blank: assert property (@(posedge clk) disable iff (rst)
      !hsync_n |-> !blank_n);

   // R5 / R6: vsync falls either together with hsync or while hsync is high
   a_r5_vs_edge_phase: assert property (@(posedge clk) disable iff (rst)
      $fell(vsync_n) |-> ($fell(hsync_n) || hsync_n));

   // R7: every vsync edge inside a running raster flips the field flag
   a_r7_field_flips: assert property (@(posedge clk) disable iff (rst)
      ($fell(vsync_n) && $past(run_w) && !$past(rst)) |-> (field_odd != $past(field_odd)));

   // R2: outputs move at sample rate, never on two clocks in a row
   a_r2_half_rate: assert property (@(posedge clk) disable iff (rst)
      (run_w && $past(run_w) && !$past(rst) && !$stable(hsync_n)) |=> (!run_w || $stable(hsync_n)));
endmodule

bind sdtv_sync_master sdtv_sync_master_chk u_chk (.*);

// File: tb/tb_sdtv_sync_master.sv
`timescale 1ns/1ps
module tb_sdtv_sync_master;
   // scaled raster: index 0 = 525-style, 1 = 625-style
   localparam int S_T  [2] = '{40, 44};
   localparam int HS_T [2] = '{4, 3};
   localparam int BL_T [2] = '{10, 12};
   localparam int N_T  [2] = '{25, 31};
   localparam int E_T  [2] = '{13, 16};
   localparam int VW_T [2] = '{26, 30};
   localparam int VH_T [2] = '{3, 4};
   localparam int ML_T [2] = '{13, 15};
   localparam int MH_T [2] = '{15, 19};
   localparam int VSL  = 3;
   localparam int WATCHDOG = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [7:0] mode_byte = 8'h05;
   logic std_625 = 1'b0;
   logic ext_blank_en = 1'b0;
   logic hsync_n, vsync_n, blank_n, field_odd;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sdtv_sync_master #(
      .SAMP_525(S_T[0]), .SAMP_625(S_T[1]),
      .HS_525(HS_T[0]), .HS_625(HS_T[1]),
      .BLK_525(BL_T[0]), .BLK_625(BL_T[1]),
      .LINES_525(N_T[0]), .LINES_625(N_T[1]),
      .EVEN_525(E_T[0]), .EVEN_625(E_T[1]),
      .VS_LINES(VSL),
      .VBW_525(VW_T[0]), .VBW_625(VW_T[1]),
      .VBH_525(VH_T[0]), .VBH_625(VH_T[1]),
      .VBML_525(ML_T[0]), .VBML_625(ML_T[1]),
      .VBMH_525(MH_T[0]), .VBMH_625(MH_T[1])
   ) dut (
      .clk(clk), .rst(rst), .mode_byte(mode_byte), .std_625(std_625),
      .ext_blank_en(ext_blank_en), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .blank_n(blank_n), .field_odd(field_odd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   // reference raster position, built from the requirements
   bit m_ph = 1'b0;
   int m_line = 1;
   int m_samp = 0;
   int m_std = 0;

   function automatic bit enabled(input logic [7:0] m);
      return m[2:0] == 3'b101;
   endfunction

   always @(posedge clk) begin
      if (rst || !enabled(mode_byte)) begin
         m_ph <= 1'b0; m_line <= 1; m_samp <= 0; m_std <= int'(std_625);
      end else begin
         m_ph <= ~m_ph;
         if (m_ph) begin
            if (m_samp == S_T[m_std] - 1) begin
               m_samp <= 0;
               if (m_line == N_T[m_std]) begin
                  m_line <= 1; m_std <= int'(std_625);
               end else m_line <= m_line + 1;
            end else m_samp <= m_samp + 1;
         end
      end
   end

   function automatic bit exp_vs(input int ln, input int sp, input int sd);
      int half = S_T[sd] / 2;
      int e = E_T[sd];
      if (ln <= VSL) return 1'b1;
      if (ln == e && sp >= half) return 1'b1;
      if (ln > e && ln < e + VSL) return 1'b1;
      if (ln == e + VSL && sp < half) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit exp_vline(input int ln, input int sd);
      return (ln >= VW_T[sd]) || (ln <= VH_T[sd]) || (ln >= ML_T[sd] && ln <= MH_T[sd]);
   endfunction

   function automatic bit exp_odd(input int ln, input int sp, input int sd);
      return (ln < E_T[sd]) || (ln == E_T[sd] && sp < S_T[sd] / 2);
   endfunction

   // per-cycle comparison, sampled on the falling edge
   logic hs_prev = 1'b1;
   int last_fall = -1;
   always @(negedge clk) begin
      bit act;
      bit e_hs, e_vs, e_bl, e_fo;
      cyc++;
      act  = !rst && enabled(mode_byte);
      e_hs = act && (m_samp < HS_T[m_std]);
      e_vs = act && exp_vs(m_line, m_samp, m_std);
      e_bl = act && ((m_samp < BL_T[m_std]) || (!ext_blank_en && exp_vline(m_line, m_std)));
      e_fo = !act || exp_odd(m_line, m_samp, m_std);
      if (!act) begin
         check(hsync_n && vsync_n && blank_n && field_odd, "R1 idle outputs",
               {hsync_n, vsync_n, blank_n, field_odd}, 15);
      end else begin
         check(hsync_n == !e_hs, "R3 hsync", hsync_n, !e_hs);
         if (m_line == 1 || m_line == E_T[m_std])
            check(vsync_n == !e_vs, (m_line == 1) ? "R5 odd vsync" : "R6 even vsync", vsync_n, !e_vs);
         else
            check(vsync_n == !e_vs, "R5 vsync span", vsync_n, !e_vs);
         if (ext_blank_en)
            check(blank_n == !e_bl, "R4 horizontal blank", blank_n, !e_bl);
         else
            check(blank_n == !e_bl, "R8 vertical blank", blank_n, !e_bl);
         check(field_odd == e_fo, "R7 field flag", field_odd, e_fo);
         // R2: line period from one hsync fall to the next
         if (hs_prev && !hsync_n) begin
            if (last_fall >= 0 && m_line != 1)
               check(cyc - last_fall == 2 * S_T[m_std], "R2 line period",
                     cyc - last_fall, 2 * S_T[m_std]);
            last_fall = cyc;
         end
      end
      if (!act) last_fall = -1;
      hs_prev = act ? hsync_n : 1'b1;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin : watchdog
      wait (cyc >= WATCHDOG);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired at cycle %0d: actual=%0d expected=%0d", cyc, cyc, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int frame0, frame1;
      void'($urandom(32'd20240611));
      frame0 = 2 * S_T[0] * N_T[0];
      frame1 = 2 * S_T[1] * N_T[1];

      // R9: reset state
      step(4);
      check(hsync_n && vsync_n && blank_n && field_odd, "R9 outputs idle in reset",
            {hsync_n, vsync_n, blank_n, field_odd}, 15);
      rst = 1'b0;
      #3;
      check(!hsync_n && !vsync_n && field_odd, "R9 restart at line 1 odd",
            {hsync_n, vsync_n, field_odd}, 1);

      // R5 R6 R8: two full 525-style frames with internal vertical blanking
      step(2 * frame0);

      // R9: standard change mid-frame is deferred to the frame wrap
      step(frame0 / 3);
      std_625 = 1'b1;
      step(frame0);
      step(2 * frame1);

      // R4: external blanking leaves only horizontal blanking
      ext_blank_en = 1'b1;
      step(frame1);
      ext_blank_en = 1'b0;

      // R1: non-master codes with upper bits set
      mode_byte = 8'hA4;
      step(40);
      check(hsync_n && vsync_n && blank_n && field_odd, "R1 disabled by code 3'b100",
            {hsync_n, vsync_n, blank_n, field_odd}, 15);
      mode_byte = 8'hFD;
      #3;
      check(!hsync_n && !vsync_n, "R1 re-enable restarts raster, upper bits ignored",
            {hsync_n, vsync_n}, 0);
      step(frame1 + 100);

      // constrained random: standard, blanking source, occasional disable
      for (int it = 0; it < 30; it++) begin
         logic [7:0] m;
         m = 8'($urandom);
         if (($urandom % 8) != 0) m[2:0] = 3'b101;
         mode_byte    = m;
         std_625      = 1'($urandom);
         ext_blank_en = (($urandom % 3) == 0);
         step(enabled(m) ? 200 + int'($urandom % 3800) : 20 + int'($urandom % 60));
      end
      mode_byte = 8'h05;
      step(frame0 + frame1);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule